// File: doc/BRIEF.md
# Calibrated ADC-to-millidegree converter

This block converts a raw code from an on-die temperature sensor ADC into a signed temperature in millidegrees Celsius. It uses calibration constants that are programmed once per die: the sensor's reference code, a signed ADC gain-error term, a signed slope offset and the calibration temperature. The arithmetic follows a fixed-point recipe:

- A scaled constant is divided twice by calibrated denominators.
- The quotient is multiplied by the offset-corrected code difference.
- The product is shifted down.
- The scaled value is subtracted from the calibration temperature times 500.

Both divisions run on one shared bit-serial divider rather than on combinational division logic. A requester holds the operands on the inputs and pulses a start strobe. The block then raises busy, works through the sequence and reports the result with a one-cycle done strobe. The result stays on the output until the next conversion completes. A start strobe that arrives while a conversion is in flight is dropped. Typical values for an uncalibrated part are gain error 512, reference code 260, calibration temperature 40 and slope offset 0.

Top module: `thermconv_top`

## Requirements
- R1: After reset, busy_o and done_o are 0 and temp_mc_o reads 0.
- R2: When busy_o is 0, start_i sampled high at a rising edge captures all five operands, and busy_o is 1 from the next cycle on.
- R3: start_i while busy_o is 1 is ignored: the operands are not recaptured, no extra done_o pulse follows, and the reported result belongs to the first request.
- R4: done_o is high for exactly one cycle, 2*DIV_W+6 rising edges after the edge that accepted start_i. In that cycle busy_o is already 0, and a start in that cycle is accepted.
- R5: The first step divides 203450520*8 by (165 + slope_ofs_i), with slope_ofs_i a two's-complement value, and truncates toward zero.
- R6: The second step divides the first quotient by (10000 + gain_err_i), with gain_err_i a two's-complement value, and truncates toward zero.
- R7: The second quotient is multiplied by (raw_code_i - ref_code_i - 3350), which may be negative. The product is then shifted right arithmetically by 3, which rounds toward minus infinity.
- R8: temp_mc_o = cal_temp_i*500 minus the shifted value, as a 32-bit two's-complement number.
- R9: temp_mc_o changes only in a cycle where done_o is 1 and holds its value otherwise.
- R10: With gain error 512, reference code 260, calibration temperature 40 and slope offset 0, raw code 3610 yields 20000 and raw code 3000 yields 91523.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request strobe |
| raw_code_i | input | 12 | Raw sensor ADC code (unsigned) |
| ref_code_i | input | 9 | Sensor reference code (unsigned) |
| gain_err_i | input | 11 | ADC gain-error term (two's complement) |
| slope_ofs_i | input | 7 | Slope offset (two's complement) |
| cal_temp_i | input | 6 | Calibration temperature in degrees (unsigned) |
| busy_o | output | 1 | Conversion in flight |
| done_o | output | 1 | One-cycle result-valid strobe |
| temp_mc_o | output | 32 | Temperature in millidegrees Celsius (two's complement) |

## Verification
The hardest cases to reach are timing windows rather than data values. The bench pulses start_i in the middle of a conversion, with different operands, and checks that only the first request is answered. It also raises start_i in the exact done cycle, where the request must be taken. A behavioural model counts the latency and holds the expected result. It is compared with busy_o, done_o and temp_mc_o on every cycle, so the result is also checked while it is being held. For the datapath, the stimulus pushes the slope offset and gain error to both ends of their signed ranges. It also makes the code difference negative and not a multiple of 8, so that truncating division and floor shifting both show up in the result.

// File: rtl/thermconv_pkg.sv
package thermconv_pkg;

  typedef enum logic [2:0] {
    CV_IDLE,
    CV_DIV1_GO,
    CV_DIV1_WAIT,
    CV_DIV2_GO,
    CV_DIV2_WAIT,
    CV_SCALE,
    CV_FINAL
  } cv_state_e;

  localparam int unsigned K_NUMER      = 203450520;
  localparam int unsigned K_NUMER_SHL  = 3;
  localparam int unsigned K_SLOPE_BASE = 165;
  localparam int unsigned K_GAIN_BASE  = 10000;
  localparam int unsigned K_CODE_OFS   = 3350;
  localparam int unsigned K_CAL_MULT   = 500;
  localparam int unsigned K_OUT_SHR    = 3;

endpackage

// File: rtl/thermconv_rstsync.sv
module thermconv_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_n;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/thermconv_sdiv.sv
// Bit-serial signed divider: one quotient bit per cycle, truncation toward zero.
module thermconv_sdiv #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic signed [W-1:0] dividend_i,
  input  logic signed [W-1:0] divisor_i,
  output logic                busy_o,
  output logic                done_o,
  output logic signed [W-1:0] quot_o
);

  localparam int CW = $clog2(W);

  logic [W-1:0]        rem_q, rem_n;
  logic [W-1:0]        quo_q, quo_n;
  logic [W-1:0]        den_q, den_n;
  logic                neg_q, neg_n;
  logic [CW-1:0]       cnt_q, cnt_n;
  logic                busy_q, busy_n;
  logic                done_q, done_n;
  logic signed [W-1:0] res_q, res_n;

  logic [W:0]   shifted;
  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] step_quo;
  logic [W-1:0] dvd_mag;
  logic [W-1:0] dvs_mag;

  always_comb begin
    dvd_mag  = dividend_i[W-1] ? (-dividend_i) : dividend_i;
    dvs_mag  = divisor_i[W-1]  ? (-divisor_i)  : divisor_i;
    shifted  = {rem_q, quo_q[W-1]};
    trial    = shifted - {1'b0, den_q};
    fits     = ~trial[W];
    step_quo = {quo_q[W-2:0], fits};
  end

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    den_n  = den_q;
    neg_n  = neg_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    res_n  = res_q;
    if (start_i && !busy_q) begin
      rem_n  = '0;
      quo_n  = dvd_mag;
      den_n  = dvs_mag;
      neg_n  = dividend_i[W-1] ^ divisor_i[W-1];
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      rem_n = fits ? trial[W-1:0] : shifted[W-1:0];
      quo_n = step_quo;
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
        res_n  = neg_q ? (-step_quo) : step_quo;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      den_q  <= den_n;
      neg_q  <= neg_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      res_q  <= res_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = res_q;

  // R4: divider completion strobe lasts one cycle
  p_div_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: the sequencer only launches a division on an idle divider
  p_div_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

endmodule

// File: rtl/thermconv_seq.sv
module thermconv_seq
  import thermconv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      div_done_i,
  output cv_state_e state_o,
  output logic      latch_o,
  output logic      div_go_o,
  output logic      take_q_o,
  output logic      scale_o,
  output logic      final_o
);

  cv_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      CV_IDLE:      if (start_i) state_n = CV_DIV1_GO;
      CV_DIV1_GO:   state_n = CV_DIV1_WAIT;
      CV_DIV1_WAIT: if (div_done_i) state_n = CV_DIV2_GO;
      CV_DIV2_GO:   state_n = CV_DIV2_WAIT;
      CV_DIV2_WAIT: if (div_done_i) state_n = CV_SCALE;
      CV_SCALE:     state_n = CV_FINAL;
      CV_FINAL:     state_n = CV_IDLE;
      default:      state_n = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CV_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  assign state_o  = state_q;
  assign latch_o  = (state_q == CV_IDLE) && start_i;
  assign div_go_o = (state_q == CV_DIV1_GO) || (state_q == CV_DIV2_GO);
  assign take_q_o = ((state_q == CV_DIV1_WAIT) || (state_q == CV_DIV2_WAIT)) && div_done_i;
  assign scale_o  = (state_q == CV_SCALE);
  assign final_o  = (state_q == CV_FINAL);

  // R2: an accepted request leaves the idle state on the next edge
  p_leave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CV_IDLE && start_i) |=> (state_q != CV_IDLE));

endmodule

// File: rtl/thermconv_top.sv
module thermconv_top
  import thermconv_pkg::*;
#(
  parameter int RAW_W   = 12,
  parameter int REF_W   = 9,
  parameter int GAIN_W  = 11,
  parameter int SLOPE_W = 7,
  parameter int CAL_W   = 6,
  parameter int RES_W   = 32,
  parameter int DIV_W   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [RAW_W-1:0]          raw_code_i,
  input  logic [REF_W-1:0]          ref_code_i,
  input  logic signed [GAIN_W-1:0]  gain_err_i,
  input  logic signed [SLOPE_W-1:0] slope_ofs_i,
  input  logic [CAL_W-1:0]          cal_temp_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic signed [RES_W-1:0]   temp_mc_o
);

  localparam int DW = DIV_W;

  logic      rst_sync_n;
  cv_state_e state;
  logic      latch_en, div_go, take_q, scale_en, final_en;
  logic      div_busy, div_done;
  logic signed [DW-1:0] div_quot;

  logic [RAW_W-1:0]          raw_q;
  logic [REF_W-1:0]          ref_q;
  logic signed [GAIN_W-1:0]  gain_q;
  logic signed [SLOPE_W-1:0] slope_q;
  logic [CAL_W-1:0]          cal_q;
  logic signed [DW-1:0]      acc_q, acc_n;
  logic signed [RES_W-1:0]   res_q, res_n;
  logic                      done_q;

  logic signed [DW-1:0] numer_w, slope_div_w, gain_div_w;
  logic signed [DW-1:0] div_a_w, div_b_w;
  logic signed [DW-1:0] code_diff_w, prod_w, scaled_w;
  logic [DW-1:0]        cal_w;

  thermconv_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  thermconv_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .div_done_i (div_done),
    .state_o    (state),
    .latch_o    (latch_en),
    .div_go_o   (div_go),
    .take_q_o   (take_q),
    .scale_o    (scale_en),
    .final_o    (final_en)
  );

  thermconv_sdiv #(.W(DW)) u_div (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (div_go),
    .dividend_i (div_a_w),
    .divisor_i  (div_b_w),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // Operand construction for the two division steps and the scaling.
  always_comb begin
    numer_w     = DW'(K_NUMER) << K_NUMER_SHL;
    slope_div_w = {{(DW-SLOPE_W){slope_q[SLOPE_W-1]}}, slope_q} + DW'(K_SLOPE_BASE);
    gain_div_w  = {{(DW-GAIN_W){gain_q[GAIN_W-1]}}, gain_q} + DW'(K_GAIN_BASE);
    div_a_w     = (state == CV_DIV2_GO) ? acc_q : numer_w;
    div_b_w     = (state == CV_DIV2_GO) ? gain_div_w : slope_div_w;
    code_diff_w = DW'(raw_q) - DW'(ref_q) - DW'(K_CODE_OFS);
    prod_w      = acc_q * code_diff_w;
    scaled_w    = acc_q >>> K_OUT_SHR;
    cal_w       = DW'(cal_q) * DW'(K_CAL_MULT);
  end

  always_comb begin
    acc_n = acc_q;
    if (take_q) begin
      acc_n = div_quot;
    end else if (scale_en) begin
      acc_n = prod_w;
    end
    res_n = res_q;
    if (final_en) begin
      res_n = RES_W'(cal_w - scaled_w);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      raw_q   <= '0;
      ref_q   <= '0;
      gain_q  <= '0;
      slope_q <= '0;
      cal_q   <= '0;
    end else if (latch_en) begin
      raw_q   <= raw_code_i;
      ref_q   <= ref_code_i;
      gain_q  <= gain_err_i;
      slope_q <= slope_ofs_i;
      cal_q   <= cal_temp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      res_q  <= res_n;
      done_q <= final_en;
    end
  end

  assign busy_o    = (state != CV_IDLE);
  assign done_o    = done_q;
  assign temp_mc_o = res_q;

  // R4: the result strobe is a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q);

  // R3: captured operands do not move while a conversion is in flight
  p_hold_operands_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |=> ($stable(raw_q) && $stable(ref_q) && $stable(gain_q)
                && $stable(slope_q) && $stable(cal_q)));

  // R9: the output only moves together with the done strobe
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(res_q) |-> done_q);

  // R5: a launched division never sees a non-positive denominator
  p_divisor_positive_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_go |-> (div_b_w > 0));

  // R4: the divider is idle whenever the sequencer reports completion
  p_div_idle_at_done_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> !div_busy);

endmodule

// File: tb/thermconv_tb.sv
module thermconv_top_tb_top;

  localparam int RAW_W   = 12;
  localparam int REF_W   = 9;
  localparam int GAIN_W  = 11;
  localparam int SLOPE_W = 7;
  localparam int CAL_W   = 6;
  localparam int RES_W   = 32;
  localparam int DIV_W   = 64;
  localparam int LAT     = 2 * DIV_W + 6;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      start_i = 1'b0;
  logic [RAW_W-1:0]          raw_code_i = '0;
  logic [REF_W-1:0]          ref_code_i = '0;
  logic signed [GAIN_W-1:0]  gain_err_i = '0;
  logic signed [SLOPE_W-1:0] slope_ofs_i = '0;
  logic [CAL_W-1:0]          cal_temp_i = '0;
  logic                      busy_o;
  logic                      done_o;
  logic signed [RES_W-1:0]   temp_mc_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  // reference model state
  bit      m_busy = 1'b0;
  bit      m_done = 1'b0;
  int      m_cnt  = 0;
  int      m_res  = 0;
  int      m_pend = 0;
  int      n_done = 0;

  always #5 clk = ~clk;

  thermconv_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .raw_code_i  (raw_code_i),
    .ref_code_i  (ref_code_i),
    .gain_err_i  (gain_err_i),
    .slope_ofs_i (slope_ofs_i),
    .cal_temp_i  (cal_temp_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .temp_mc_o   (temp_mc_o)
  );

  function automatic int expect_temp(int raw, int rf, int ge, int sl, int cal);
    longint t;
    t = 64'sd203450520 <<< 3;
    t = t / longint'(165 + sl);
    t = t / longint'(10000 + ge);
    t = t * longint'(raw - rf - 3350);
    t = t >>> 3;
    return int'(longint'(cal) * 500 - t);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_res = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          m_res  = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1'b1;
        m_cnt  = LAT;
        m_pend = expect_temp(int'(raw_code_i), int'(ref_code_i), int'(gain_err_i),
                             int'(slope_ofs_i), int'(cal_temp_i));
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy", longint'(busy_o), longint'(m_busy));
      check("R4 done", longint'(done_o), longint'(m_done));
      check("R8/R9 result", longint'(temp_mc_o), longint'(m_res));
      if (done_o) n_done++;
    end
  end

  task automatic drive(int raw, int rf, int ge, int sl, int cal);
    raw_code_i  = RAW_W'(raw);
    ref_code_i  = REF_W'(rf);
    gain_err_i  = GAIN_W'(ge);
    slope_ofs_i = SLOPE_W'(sl);
    cal_temp_i  = CAL_W'(cal);
  endtask

  task automatic run_op(string tag, int raw, int rf, int ge, int sl, int cal);
    int exp_v;
    exp_v = expect_temp(raw, rf, ge, sl, cal);
    @(negedge clk);
    drive(raw, rf, ge, sl, cal);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check(tag, longint'(temp_mc_o), longint'(exp_v));
    @(negedge clk);
  endtask

  initial begin
    int exp_a;
    int done_before;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", longint'(busy_o), 0);
    check("R1 done", longint'(done_o), 0);
    check("R1 result", longint'(temp_mc_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after release", longint'(busy_o), 0);

    // R10: default calibration
    run_op("R10 raw 3610", 3610, 260, 512, 0, 40);
    check("R10 literal 20000", longint'(temp_mc_o), 20000);
    run_op("R10 raw 3000", 3000, 260, 512, 0, 40);
    check("R10 literal 91523", longint'(temp_mc_o), 91523);

    // R5 / R6: signed slope and gain extremes
    run_op("R5 slope min", 3700, 300, 0, -64, 30);
    run_op("R5 slope max", 3700, 300, 0, 63, 30);
    run_op("R6 gain min", 2500, 100, -1024, 5, 50);
    run_op("R6 gain max", 2500, 100, 1023, -5, 50);

    // R7: negative difference not a multiple of 8, and large positive one
    run_op("R7 negative diff", 3605, 260, 512, 0, 40);
    run_op("R7 positive diff", 4095, 0, -300, -20, 63);
    run_op("R7 zero diff", 3850, 500, 200, 10, 0);

    // R3: start during a conversion is dropped
    exp_a = expect_temp(3200, 250, 400, 12, 45);
    done_before = n_done;
    @(negedge clk);
    drive(3200, 250, 400, 12, 45);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    drive(100, 7, -900, -60, 3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R3 first operands kept", longint'(temp_mc_o), longint'(exp_a));
    repeat (LAT + 10) @(negedge clk);
    check("R3 single done", longint'(n_done - done_before), 1);

    // R4: start raised in the done cycle is accepted
    drive(3400, 260, 512, 0, 40);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    drive(3900, 260, 512, 0, 40);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R4 restart busy", longint'(busy_o), 1);
    while (!done_o) @(negedge clk);
    check("R4 restart result", longint'(temp_mc_o), longint'(expect_temp(3900, 260, 512, 0, 40)));

    // R9: held result over idle cycles (compared per cycle too)
    repeat (30) @(negedge clk);
    check("R9 held", longint'(temp_mc_o), longint'(expect_temp(3900, 260, 512, 0, 40)));

    // mixed patterns
    for (int k = 0; k < 16; k++) begin
      int r, f, g, s, c;
      r = int'($urandom_range(4095, 0));
      f = int'($urandom_range(511, 0));
      g = int'($urandom_range(2047, 0)) - 1024;
      s = int'($urandom_range(127, 0)) - 64;
      c = int'($urandom_range(63, 0));
      run_op("R8 mixed", r, f, g, s, c);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule